// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into parallel characters. The line is sampled once per pulse of a 16x oversampling enable. A falling edge begins a candidate start bit, and that start bit is confirmed at its midpoint. The receiver then shifts in 5 to 8 data bits, least significant first. It checks an optional even or odd parity bit and samples the first stop bit. Every finished character appears on the outputs with a one-clock valid strobe, together with a parity-error, framing-error and break flag.

The line settings are captured when a start bit is first seen, so a change to them part-way through a character has no effect until the next one. A framing error arms a stricter start check for the following character. A line that stays low for longer than a whole frame yields one all-zero break character. The receiver then stays silent until the line goes high again. Storage, software registers and the baud generator belong to the surrounding logic.

Top module: `uart_rx_deser`

## Requirements
- R1: After reset, chr_valid, chr_data, chr_perr, chr_ferr and chr_brk are all zero.
- R2: cfg_wlen values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits are received least significant first and placed right-aligned in chr_data, and the unused upper bits read zero. A clean character has all three flags low.
- R3: When cfg_par_en is 1, a parity bit follows the data. cfg_par_odd set to 0 asks for even parity and set to 1 asks for odd parity, counted over the data and parity bits. A mismatch sets chr_perr, and the data is still delivered.
- R4: Only the first stop bit is checked. A low level at its midpoint sets chr_ferr, and the received data is still delivered. When cfg_stop2 is 1, a second stop bit is expected, but its level is never checked.
- R5: Ticks are counted with index k, where k=0 is the first tick that sees the line low, and each bit spans 16 ticks. A start bit is sampled only at k=7. If the line is high at k=7, the attempt is dropped with no output.
- R6: After a character flagged with chr_ferr, the next start bit must be low at both k=6 and k=7. Otherwise it is dropped with no output.
- R7: The frame length is F = 16 x (1 + data bits + parity bit + stop bits). If the line is low at every tick from k=0 to k=F, exactly one character is delivered at the tick k=F. That character has chr_data zero, chr_brk=1, chr_perr=0 and chr_ferr=0.
- R8: After a break character, no further character is produced while the line stays low. Reception resumes with a new start bit once the line has been seen high.
- R9: The line may be low from k=0 through the first stop bit's midpoint and then return high before k=F. In that case one character with chr_data zero and chr_ferr=1 is delivered at the first tick that sees the line high.
- R10: chr_valid is high for exactly one clock. It rises on the clock after the tick that takes the deciding sample, so for a normal character this is the tick at the stop-bit midpoint.
- R11: cfg_wlen, cfg_par_en, cfg_par_odd and cfg_stop2 are captured at the tick with k=0. Changing them during a character does not alter how that character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-clock enable at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high; it passes through a 2-flop synchronizer |
| cfg_wlen | input | 2 | Data bit count: value + 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| chr_valid | output | 1 | One-clock character strobe |
| chr_data | output | 8 | Received data, right-aligned |
| chr_perr | output | 1 | Parity error flag |
| chr_ferr | output | 1 | Framing error flag |
| chr_brk | output | 1 | Break flag |

## Verification
A wrong tick count or bit index inside the receiver shows at the ports within one character. Data then comes out shifted by one bit position, a parity flag is set on clean data, or the strobe arrives a tick early or late. The bench therefore checks the exact tick at which the strobe rises. A resynchronization or break-wait state that is held too long, or cleared too early, shows as missing or extra characters. This appears only on the character after the fault, which is why the bench runs framing errors, glitches and breaks back to back and counts every strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD, ST_BRKW
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } line_cfg_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{IDLE_LVL}};
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_framelen.sv
module uart_rx_framelen
  import uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int MAXW = 8,
  parameter int KW   = 8,
  parameter int BW   = 4
) (
  input  line_cfg_t        cfg,
  output logic [BW-1:0]    nbits,
  output logic [KW-1:0]    frame_ticks
);
  localparam int MINW = MAXW - 3;

  logic [BW-1:0] nsym;

  always_comb begin
    nbits       = BW'(MINW) + BW'(cfg.wlen);
    nsym        = nbits + BW'(2) + BW'(cfg.par_en) + BW'(cfg.stop2);
    frame_ticks = KW'(OVS) * KW'(nsym);
  end
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift #(
  parameter int MAXW = 8,
  parameter int BW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            cap,
  input  logic            par_cap,
  input  logic [BW-1:0]   idx,
  input  logic            bit_in,
  output logic [MAXW-1:0] data,
  output logic            par_acc
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data    <= '0;
      par_acc <= 1'b0;
    end else begin
      for (int i = 0; i < MAXW; i++) begin
        if (cap && idx == BW'(i)) data[i] <= bit_in;
      end
      if (cap || par_cap) par_acc <= par_acc ^ bit_in;
    end
  end

  // R2
  cap_idx_chk: assert property (@(posedge clk) disable iff (rst)
    cap |-> (idx < BW'(MAXW)));
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int MAXW = 8,
  parameter int KW   = 8,
  parameter int BW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            rx,
  input  line_cfg_t       cfg_in,
  output line_cfg_t       cfg_q,
  input  logic [BW-1:0]   nbits,
  input  logic [KW-1:0]   frame_ticks,
  input  logic [MAXW-1:0] sh_data,
  input  logic            sh_par,
  output logic            sh_clr,
  output logic            sh_cap,
  output logic            sh_par_cap,
  output logic [BW-1:0]   sh_idx,
  output logic            chr_valid,
  output logic [MAXW-1:0] chr_data,
  output logic            chr_perr,
  output logic            chr_ferr,
  output logic            chr_brk
);
  localparam int SB = $clog2(OVS);
  localparam logic [SB-1:0] MID = SB'(OVS/2 - 1);
  localparam logic [SB-1:0] PRE = SB'(OVS/2 - 2);

  rx_state_e     state_q;
  logic [KW-1:0] ftick_q;
  logic          all_low_q;
  logic          resync_q;
  logic [SB-1:0] phase;
  logic [BW-1:0] bidx;
  logic          perr_now;

  assign phase      = ftick_q[SB-1:0];
  assign bidx       = BW'(ftick_q >> SB);
  assign perr_now   = cfg_q.par_en & (sh_par ^ cfg_q.par_odd);
  assign sh_clr     = tick && state_q == ST_IDLE && !rx;
  assign sh_cap     = tick && state_q == ST_DATA && phase == MID;
  assign sh_par_cap = tick && state_q == ST_PAR && phase == MID;
  assign sh_idx     = bidx - BW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ftick_q   <= '0;
      all_low_q <= 1'b0;
      resync_q  <= 1'b0;
      cfg_q     <= '0;
      chr_valid <= 1'b0;
      chr_data  <= '0;
      chr_perr  <= 1'b0;
      chr_ferr  <= 1'b0;
      chr_brk   <= 1'b0;
    end else begin
      chr_valid <= 1'b0;
      if (tick) begin
        if (state_q != ST_IDLE && state_q != ST_BRKW) ftick_q <= ftick_q + KW'(1);
        all_low_q <= all_low_q & ~rx;
        case (state_q)
          ST_IDLE: begin
            if (!rx) begin
              state_q   <= ST_START;
              ftick_q   <= KW'(1);
              all_low_q <= 1'b1;
              cfg_q     <= cfg_in;
            end
          end
          ST_START: begin
            if (resync_q && phase == PRE && rx) begin
              state_q <= ST_IDLE;
            end else if (phase == MID) begin
              if (rx) state_q <= ST_IDLE;
              else begin
                state_q  <= ST_DATA;
                resync_q <= 1'b0;
              end
            end
          end
          ST_DATA: begin
            if (phase == MID && bidx == nbits)
              state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            if (phase == MID) state_q <= ST_STOP;
          end
          ST_STOP: begin
            if (phase == MID) begin
              if (rx) begin
                state_q   <= ST_IDLE;
                chr_valid <= 1'b1;
                chr_data  <= sh_data;
                chr_perr  <= perr_now;
                chr_ferr  <= 1'b0;
                chr_brk   <= 1'b0;
              end else if (all_low_q) begin
                state_q <= ST_HOLD;
              end else begin
                state_q   <= ST_IDLE;
                resync_q  <= 1'b1;
                chr_valid <= 1'b1;
                chr_data  <= sh_data;
                chr_perr  <= perr_now;
                chr_ferr  <= 1'b1;
                chr_brk   <= 1'b0;
              end
            end
          end
          ST_HOLD: begin
            if (rx) begin
              state_q   <= ST_IDLE;
              resync_q  <= 1'b1;
              chr_valid <= 1'b1;
              chr_data  <= sh_data;
              chr_perr  <= perr_now;
              chr_ferr  <= 1'b1;
              chr_brk   <= 1'b0;
            end else if (ftick_q == frame_ticks) begin
              state_q   <= ST_BRKW;
              chr_valid <= 1'b1;
              chr_data  <= '0;
              chr_perr  <= 1'b0;
              chr_ferr  <= 1'b0;
              chr_brk   <= 1'b1;
            end
          end
          ST_BRKW: begin
            if (rx) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    chr_valid |=> !chr_valid);

  // R10
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> $past(tick));

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    chr_valid |-> ((chr_data >> nbits) == '0));

  // R8
  brk_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BRKW) |=> !chr_valid);

  // R7
  brk_char_chk: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && chr_brk) |-> (chr_data == '0 && !chr_ferr && !chr_perr));

  // R4
  stop_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && state_q == ST_STOP && phase == MID) |->
      (bidx == nbits + BW'(1) + BW'(cfg_q.par_en)));

  // R7
  frame_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && state_q != ST_BRKW) |-> (ftick_q <= frame_ticks));
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int MAXW        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            os_tick,
  input  logic            rx_in,
  input  logic [1:0]      cfg_wlen,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_stop2,
  output logic            chr_valid,
  output logic [MAXW-1:0] chr_data,
  output logic            chr_perr,
  output logic            chr_ferr,
  output logic            chr_brk
);
  localparam int KW = $clog2(OVS * (MAXW + 4) + 1);
  localparam int BW = $clog2(MAXW + 5);

  logic            rx_s;
  line_cfg_t       cfg_in, cfg_q;
  logic [BW-1:0]   nbits;
  logic [KW-1:0]   frame_ticks;
  logic [MAXW-1:0] sh_data;
  logic            sh_par, sh_clr, sh_cap, sh_par_cap;
  logic [BW-1:0]   sh_idx;

  assign cfg_in = '{wlen: cfg_wlen, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, stop2: cfg_stop2};

  uart_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(rx_s)
  );

  uart_rx_framelen #(.OVS(OVS), .MAXW(MAXW), .KW(KW), .BW(BW)) u_len (
    .cfg(cfg_q), .nbits(nbits), .frame_ticks(frame_ticks)
  );

  uart_rx_shift #(.MAXW(MAXW), .BW(BW)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .cap(sh_cap), .par_cap(sh_par_cap),
    .idx(sh_idx), .bit_in(rx_s), .data(sh_data), .par_acc(sh_par)
  );

  uart_rx_ctrl #(.OVS(OVS), .MAXW(MAXW), .KW(KW), .BW(BW)) u_ctrl (
    .clk(clk), .rst(rst), .tick(os_tick), .rx(rx_s), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .nbits(nbits), .frame_ticks(frame_ticks),
    .sh_data(sh_data), .sh_par(sh_par), .sh_clr(sh_clr), .sh_cap(sh_cap),
    .sh_par_cap(sh_par_cap), .sh_idx(sh_idx),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_perr(chr_perr),
    .chr_ferr(chr_ferr), .chr_brk(chr_brk)
  );
endmodule

// File: tb/sim_uart_rx_deser.sv
`timescale 1ns/1ps
module sim_uart_rx_deser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic rx_in = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic chr_valid;
  logic [7:0] chr_data;
  logic chr_perr, chr_ferr, chr_brk;

  int checks = 0, errors = 0, ev_cnt = 0, wide_cnt = 0;
  logic [7:0] last_d = '0;
  logic last_p = 0, last_f = 0, last_b = 0, prev_v = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_deser u0 (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_brk(chr_brk)
  );

  always @(negedge clk) begin
    if (chr_valid) begin
      ev_cnt++;
      last_d = chr_data; last_p = chr_perr; last_f = chr_ferr; last_b = chr_brk;
      if (prev_v) wide_cnt++;
    end
    prev_v = chr_valid;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one 16x tick: line value settles through the synchronizer first
  task automatic tk(bit v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_in = v; os_tick = 0;
      repeat (2) @(negedge clk);
      os_tick = 1;
      @(negedge clk); os_tick = 0;
    end
  endtask

  task automatic set_cfg(int n, bit pen, bit odd, bit s2);
    cfg_wlen = 2'(n - 5); cfg_par_en = pen; cfg_par_odd = odd; cfg_stop2 = s2;
  endtask

  function automatic logic [7:0] msk(int n);
    return 8'hFF >> (8 - n);
  endfunction

  task automatic send_frame(int n, bit pen, bit odd, bit s2, logic [7:0] d, bit flip);
    logic [7:0] dm;
    dm = d & msk(n);
    tk(0, 16);
    for (int i = 0; i < n; i++) tk(dm[i], 16);
    if (pen) tk((^dm) ^ odd ^ flip, 16);
    tk(1, s2 ? 32 : 16);
    tk(1, 16);
    #1;
  endtask

  task automatic exp_char(string req, int base, logic [7:0] ed, bit ep, bit ef, bit eb);
    chk(ev_cnt == base + 1, req, "char count", ev_cnt - base, 1);
    chk(last_d == ed, req, "data", last_d, ed);
    chk(last_p == ep, req, "perr", last_p, ep);
    chk(last_f == ef, req, "ferr", last_f, ef);
    chk(last_b == eb, req, "brk", last_b, eb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    int base;
    logic [7:0] d;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA3;

    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(chr_valid == 0, "R1", "valid", chr_valid, 0);
    chk(chr_data == 0, "R1", "data", chr_data, 0);
    chk({chr_perr, chr_ferr, chr_brk} == 3'b000, "R1", "flags",
        {chr_perr, chr_ferr, chr_brk}, 0);
    tk(1, 32);

    // R2 / R3 sweep over word length, parity mode, stop count
    for (int w = 5; w <= 8; w++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int p = 0; p < 4; p++) begin
          set_cfg(w, pm != 0, pm == 2, w[0]);
          base = ev_cnt;
          send_frame(w, pm != 0, pm == 2, w[0], pats[p], 0);
          exp_char(pm != 0 ? "R3" : "R2", base, pats[p] & msk(w), 0, 0, 0);
        end
      end
    end

    // R3 wrong parity, both senses
    for (int o = 0; o < 2; o++) begin
      set_cfg(7, 1, o[0], 0);
      base = ev_cnt;
      send_frame(7, 1, o[0], 0, 8'h4B, 1);
      exp_char("R3", base, 8'h4B, 1, 0, 0);
    end

    // R5 short glitch dropped
    set_cfg(8, 0, 0, 0);
    base = ev_cnt;
    tk(0, 5); tk(1, 100); #1;
    chk(ev_cnt == base, "R5", "glitch chars", ev_cnt - base, 0);

    // R5 only the k=7 sample decides in normal mode
    base = ev_cnt;
    tk(0, 6); tk(1, 1); tk(0, 1); tk(1, 16 * 8); tk(1, 32); #1;
    exp_char("R5", base, 8'hFF, 0, 0, 0);

    // R10 strobe timing at stop-bit midpoint
    d = 8'h96;
    base = ev_cnt;
    tk(0, 16);
    for (int i = 0; i < 8; i++) tk(d[i], 16);
    tk(1, 7); #1;
    chk(ev_cnt == base, "R10", "early strobe", ev_cnt - base, 0);
    tk(1, 1); #1;
    exp_char("R10", base, 8'h96, 0, 0, 0);
    tk(1, 24);

    // R4 second stop bit not checked
    set_cfg(6, 0, 0, 1);
    d = 8'h2D;
    base = ev_cnt;
    tk(0, 16);
    for (int i = 0; i < 6; i++) tk(d[i], 16);
    tk(1, 16); tk(0, 4); tk(1, 64); #1;
    exp_char("R4", base, 8'h2D, 0, 0, 0);

    // R11 settings changed mid-character are ignored
    set_cfg(8, 0, 0, 0);
    d = 8'hC6;
    base = ev_cnt;
    tk(0, 16); tk(d[0], 16);
    set_cfg(5, 1, 1, 1);
    for (int i = 1; i < 8; i++) tk(d[i], 16);
    tk(1, 32); #1;
    exp_char("R11", base, 8'hC6, 0, 0, 0);
    set_cfg(8, 0, 0, 0);

    // R4 framing error keeps data
    d = 8'h3C;
    base = ev_cnt;
    tk(0, 16);
    for (int i = 0; i < 8; i++) tk(d[i], 16);
    tk(0, 8); tk(1, 40); #1;
    exp_char("R4", base, 8'h3C, 0, 1, 0);

    // R6 after framing error a start high at k=6 is dropped
    base = ev_cnt;
    tk(0, 6); tk(1, 1); tk(0, 1); tk(1, 200); #1;
    chk(ev_cnt == base, "R6", "resync chars", ev_cnt - base, 0);
    base = ev_cnt;
    send_frame(8, 0, 0, 0, 8'h81, 0);
    exp_char("R6", base, 8'h81, 0, 0, 0);

    // R7 break at exactly k=F, 8N1 gives F=160
    base = ev_cnt;
    tk(0, 160); #1;
    chk(ev_cnt == base, "R7", "chars before F", ev_cnt - base, 0);
    tk(0, 1); #1;
    exp_char("R7", base, 8'h00, 0, 0, 1);
    // R8 silent while low
    tk(0, 300); #1;
    chk(ev_cnt == base + 1, "R8", "chars while low", ev_cnt - base, 1);
    tk(1, 32);
    base = ev_cnt;
    send_frame(8, 0, 0, 0, 8'h5A, 0);
    exp_char("R8", base, 8'h5A, 0, 0, 0);

    // R7 frame length from settings: 5 bits, odd parity, 2 stops gives F=144
    set_cfg(5, 1, 1, 1);
    base = ev_cnt;
    tk(0, 144); #1;
    chk(ev_cnt == base, "R7", "chars before F", ev_cnt - base, 0);
    tk(0, 1); #1;
    exp_char("R7", base, 8'h00, 0, 0, 1);
    tk(1, 32);

    // R9 all-low frame released before F
    set_cfg(8, 0, 0, 0);
    base = ev_cnt;
    tk(0, 156); #1;
    chk(ev_cnt == base, "R9", "chars while low", ev_cnt - base, 0);
    tk(1, 1); #1;
    exp_char("R9", base, 8'h00, 0, 1, 0);
    tk(1, 32);

    // R10 strobe width over the whole run
    chk(wide_cnt == 0, "R10", "wide strobes", wide_cnt, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule